// File: doc/BRIEF.md
# 67-to-20 Bit Transmit Gearbox

The block takes 67-bit encoded words (a 3-bit header plus a 64-bit payload) and repacks them into a continuous stream of 20-bit lane words for a serializer. Leftover bits are kept in a residue buffer. Whenever that buffer holds at least 20 bits, the oldest 20 bits leave as one lane word. Bit order is kept end to end: the header goes out first, most significant bit first, then the payload from bit 63 down to bit 0. The oldest bit always sits in the most significant position of the lane word.

The input side uses a valid/ready handshake. The lane side has no backpressure: a lane word is taken in every cycle in which it is flagged valid. Twenty bits leave per cycle but only 67 bits arrive per accepted word, so the block throttles its input. It accepts a word only when the bits that remain after the current cycle's lane word, plus 67 new bits, fit in an 86-bit buffer. Each input word then gives three or four lane words. While words are offered, the lane stream has no gaps.

Top module: `gbx67_tx`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `in_ready` are both 0. Within three clock edges after `rst_n` rises, `in_ready` is 1 and `out_valid` is still 0.
- R2: An accepted word is emitted in this order: header bit 2 first, then header bits 1 and 0, then payload bits 63 down to 0. The first lane word after reset, counting from its bit 19, therefore carries the header followed by payload bits 63 to 47.
- R3: `out_valid` is 1 in a cycle exactly when the buffer holds 20 or more bits. The buffer holds all accepted bits minus 20 for each lane word already emitted.
- R4: `out_word` carries the 20 oldest buffered bits, with the oldest in bit 19. Those bits are removed in the same cycle.
- R5: `in_ready` is 1 exactly when (held bits, minus 20 if a lane word leaves this cycle) is 19 or less.
- R6: The buffer never holds more than 86 bits.
- R7: Once the first word has been accepted, `out_valid` stays 1 in every cycle for as long as `in_valid` is held at 1.
- R8: After reset, the first lane word is valid in the cycle right after the first accepted input word.
- R9: A word offered while `in_ready` is 0 is not taken. None of its bits appear in the lane stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted when both this and `in_valid` are 1 |
| in_hdr | input | 3 | Header bits, sent first, MSB first |
| in_data | input | 64 | Payload bits, sent after the header, MSB first |
| out_valid | output | 1 | `out_word` holds a lane word this cycle |
| out_word | output | 20 | Lane word, oldest bit in bit 19 |

## Verification
Four directed payloads check that bits are never reordered, dropped or duplicated across word boundaries:
- all-ones header over a zero payload,
- zero header over an all-ones payload,
- a payload with only its end bits set,
- an alternating pattern.

A header-only pattern is read straight off the first lane word after a fresh reset. This separates a correct bit order from a swapped header or payload order, and it also pins down the cycle of the first output. Continuous offering shows that the lane stream has no gaps and that the input is refused at the right buffer fill. Random gaps in `in_valid` with random payloads drive every residue offset from 0 to 19 through both the three-word and the four-word cases.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  parameter int unsigned GBX_HDR_W  = 3;
  parameter int unsigned GBX_DATA_W = 64;
  parameter int unsigned GBX_LANE_W = 20;

  // bits needed to count 0..maxv
  function automatic int unsigned gbx_cnt_bits(input int unsigned maxv);
    return $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/gbx_occupancy.sv
module gbx_occupancy #(
  parameter int unsigned IN_W   = 67,
  parameter int unsigned LANE_W = 20,
  parameter int unsigned BUF_W  = 86,
  parameter int unsigned CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             out_valid,
  output logic             push,
  output logic [CNT_W-1:0] cnt_left
);
  localparam logic [CNT_W-1:0] LANE_C  = CNT_W'(LANE_W);
  localparam logic [CNT_W-1:0] IN_C    = CNT_W'(IN_W);
  localparam logic [CNT_W-1:0] ROOM_C  = CNT_W'(BUF_W - IN_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    out_valid = (cnt_q >= LANE_C);
    cnt_left  = out_valid ? (cnt_q - LANE_C) : cnt_q;
    in_ready  = run_en && (cnt_left <= ROOM_C);
    push      = in_valid && in_ready;
    cnt_d     = push ? (cnt_left + IN_C) : cnt_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (out_valid || push) cnt_q <= cnt_d;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUF_W));

  // R3
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !push) |=> (cnt_q == $past(cnt_q) - LANE_C));

  // R5
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !out_valid) |-> in_ready);

  // R7
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> out_valid);

  // R8
  first_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(push));
endmodule

// File: rtl/gbx_residue.sv
module gbx_residue #(
  parameter int unsigned IN_W   = 67,
  parameter int unsigned LANE_W = 20,
  parameter int unsigned BUF_W  = 86,
  parameter int unsigned CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              push,
  input  logic [CNT_W-1:0]  cnt_left,
  input  logic [IN_W-1:0]   in_word,
  output logic [LANE_W-1:0] out_word
);
  localparam int unsigned PAD_W = BUF_W - IN_W;

  // valid bits are left-aligned: oldest bit at BUF_W-1
  logic [BUF_W-1:0] buf_q, buf_d, shifted, aligned;

  always_comb begin
    shifted = pop ? (buf_q << LANE_W) : buf_q;
    aligned = {in_word, {PAD_W{1'b0}}} >> cnt_left;
    buf_d   = push ? (shifted | aligned) : shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           buf_q <= '0;
    else if (pop || push) buf_q <= buf_d;
  end

  assign out_word = buf_q[BUF_W-1 -: LANE_W];

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !push) |=> $stable(out_word));
endmodule

// File: rtl/gbx67_tx.sv
module gbx67_tx
  import gbx_pkg::*;
#(
  parameter int unsigned HDR_W  = GBX_HDR_W,
  parameter int unsigned DATA_W = GBX_DATA_W,
  parameter int unsigned LANE_W = GBX_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_word
);
  localparam int unsigned IN_W  = HDR_W + DATA_W;
  localparam int unsigned BUF_W = IN_W + LANE_W - 1;
  localparam int unsigned CNT_W = gbx_cnt_bits(BUF_W);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             push;
  logic [CNT_W-1:0] cnt_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gbx_occupancy #(
    .IN_W(IN_W), .LANE_W(LANE_W), .BUF_W(BUF_W), .CNT_W(CNT_W)
  ) i_occ (
    .clk(clk), .rst_n(rst_int_n), .run_en(rst_int_n),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .push(push), .cnt_left(cnt_left)
  );

  gbx_residue #(
    .IN_W(IN_W), .LANE_W(LANE_W), .BUF_W(BUF_W), .CNT_W(CNT_W)
  ) i_res (
    .clk(clk), .rst_n(rst_int_n), .pop(out_valid), .push(push),
    .cnt_left(cnt_left), .in_word({in_hdr, in_data}), .out_word(out_word)
  );
endmodule

// File: tb/test_gbx67_tx.sv
`timescale 1ns/1ps
module test_gbx67_tx;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_hdr;
  logic [63:0] in_data;
  logic        out_valid;
  logic [19:0] out_word;

  int n_chk, n_bad;
  bit done;
  logic mq [0:1023];
  int   m_head, m_cnt;

  gbx67_tx i_gbx67_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_data(in_data), .out_valid(out_valid), .out_word(out_word)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] model_word();
    logic [19:0] w;
    for (int i = 0; i < 20; i++) w[19-i] = mq[(m_head + i) % 1024];
    return w;
  endfunction

  function automatic bit model_ready();
    int left;
    left = (m_cnt >= 20) ? m_cnt - 20 : m_cnt;
    return left <= 19;
  endfunction

  // one cycle: drive, compare at this negedge, update model, advance
  task automatic cycle(input bit v, input logic [2:0] h, input logic [63:0] d);
    bit hs;
    logic [66:0] w;
    in_valid = v; in_hdr = h; in_data = d;
    hs = v && in_ready;
    check(in_ready == model_ready(), "R5", 64'(in_ready), 64'(model_ready()));
    check(out_valid == (m_cnt >= 20), "R3", 64'(out_valid), 64'(m_cnt >= 20));
    check(m_cnt <= 86, "R6", 64'(m_cnt), 64'd86);
    if (m_cnt >= 20) begin
      check(out_word == model_word(), "R4/R9", 64'(out_word), 64'(model_word()));
      m_head = (m_head + 20) % 1024;
      m_cnt  = m_cnt - 20;
    end
    if (hs) begin
      w = {h, d};
      for (int i = 66; i >= 0; i--) begin
        mq[(m_head + m_cnt) % 1024] = w[i];
        m_cnt++;
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_hdr = '0; in_data = '0;
    rst_n = 1'b0;
    m_head = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    check(in_ready == 1'b0, "R1", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
  endtask

  task automatic run_stream(input logic [2:0] h, input logic [63:0] d, input int ncyc);
    int gaps;
    bit started;
    gaps = 0; started = 0;
    for (int c = 0; c < ncyc; c++) begin
      if (started && !out_valid) gaps++;
      if (in_ready) started = 1;
      cycle(1'b1, h, d ^ 64'(c));
    end
    // R7
    check(gaps == 0, "R7", 64'(gaps), 64'd0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    void'($urandom(32'h5eed));
    @(negedge clk);
    do_reset();

    // R2 and R8: first word after reset
    check(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);
    cycle(1'b1, 3'b101, 64'hF0F0_1234_5678_9ABC);
    check(out_valid == 1'b1, "R8", 64'(out_valid), 64'd1);
    check(out_word == {3'b101, 17'(64'hF0F0_1234_5678_9ABC >> 47)}, "R2",
          64'(out_word), 64'({3'b101, 17'(64'hF0F0_1234_5678_9ABC >> 47)}));
    cycle(1'b0, '0, '0);

    run_stream(3'b111, 64'h0, 60);
    run_stream(3'b000, 64'hFFFF_FFFF_FFFF_FFFF, 60);
    run_stream(3'b010, 64'h8000_0000_0000_0001, 60);
    run_stream(3'b110, 64'hAAAA_AAAA_AAAA_AAAA, 60);

    // drain, then mid-run reset
    repeat (10) cycle(1'b0, '0, '0);
    do_reset();
    cycle(1'b1, 3'b011, 64'h0123_4567_89AB_CDEF);
    check(out_valid == 1'b1, "R8", 64'(out_valid), 64'd1);

    // random offering with gaps
    for (int c = 0; c < 4000; c++) begin
      cycle(($urandom % 100) < 60, 3'($urandom), {$urandom, $urandom});
    end
    repeat (10) cycle(1'b0, '0, '0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule